// File: doc/BRIEF.md
# Eight-Bit ALU with Status Flag Generation

This block is the arithmetic and logic stage of a small 8-bit microcontroller datapath. Each cycle it takes two operands, a carry input, the current status flags and a 5-bit operation code. On the next rising clock edge it presents the result, a result write strobe, the updated flag vector and a per-flag write mask. The surrounding core uses the mask to merge the new flags into its status register.

Flags that an operation leaves alone appear on `flags_out` with their incoming value, so `flags_out` can be written back whole. The compare-with-carry and subtract-with-carry forms can only clear the zero flag. Because of this, a chain of byte compares ends with Z set only when every byte matched. Increment and decrement never touch carry, so loop counters can sit between the steps of a multi-byte add without disturbing it.

Top module: `mcu_alu`

## Requirements
- R1: Outputs are registered. `result`, `result_we`, `flags_out` and `flags_we` reflect the inputs present at the previous rising edge. A synchronous active-high `rst` drives all four outputs to zero.
- R2: ADD (op 0) and ADC (op 1) give a+b, with ADC also adding `carry_in`, modulo 256. C is the carry out of bit 7, H is the carry out of bit 3, and V flags signed overflow. All six flags are written.
- R3: SUB (2), SBC (3), CP (4) and CPC (5) give a-b, with SBC and CPC also subtracting `carry_in`. C is set when b plus borrow exceeds a unsigned, H is the borrow out of the low nibble, and V flags signed overflow. All six flags are written.
- R4: For SBC and CPC, Z equals the incoming Z AND (result==0). For every other op that writes Z, Z is simply result==0.
- R5: `result_we` is 1 for every defined op except CP and CPC. Op codes 17 to 31 give result=a, `result_we`=0 and no flag writes.
- R6: Whenever written, N equals result bit 7 and S equals N XOR V.
- R7: AND (6), OR (7) and XOR (8) clear V and write Z, N, V and S. They do not write C or H.
- R8: COM (9) gives the bitwise inverse of a, sets C to 1 and clears V. It writes C, Z, N, V and S.
- R9: NEG (10) gives 0-a. C is set when the result is non-zero, V is set when the result is 0x80, and H is the low-nibble borrow. All six flags are written.
- R10: INC (11) and DEC (12) give a+1 and a-1. V is set on INC of 0x7F and on DEC of 0x80. Only Z, N, V and S are written, so C passes through unchanged.
- R11: LSR (14), ROR (15) and ASR (16) shift a right by one, with bit 0 going to C. The new bit 7 is 0 for LSR, `carry_in` for ROR and a[7] for ASR. V equals N XOR C. C, Z, N, V and S are written; H is not.
- R12: SWAP (13) exchanges the high and low nibbles of a and writes no flag.
- R13: The flag vector layout is bit 0 C, bit 1 Z, bit 2 N, bit 3 V, bit 4 S, bit 5 H. Every flag whose `flags_we` bit is 0 appears on `flags_out` with its `flags_in` value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 5 | Operation code |
| a | input | 8 | First operand (destination) |
| b | input | 8 | Second operand |
| carry_in | input | 1 | Carry/borrow input for chained and rotate ops |
| flags_in | input | 6 | Current status flags (layout as R13) |
| result | output | 8 | Registered result |
| result_we | output | 1 | Result should be written back |
| flags_out | output | 6 | Registered flag vector |
| flags_we | output | 6 | Per-flag write mask |

## Verification
The properties assume that `op`, `a` and `flags_in` hold known values at every clock edge after reset. Several properties compare registered outputs against the `$past` value of these inputs, so an unknown code would make them meaningless. The stimulus drives every input on the falling edge from a table and from directed sequences. It keeps every input defined from the first cycle of reset onward. Undefined op codes are applied on purpose, but only as defined binary values.

// File: rtl/mcu_alu_pkg.sv
package mcu_alu_pkg;
  localparam int NFLAG = 6;
  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FN = 2;
  localparam int FV = 3;
  localparam int FS = 4;
  localparam int FH = 5;

  localparam logic [NFLAG-1:0] WE_ALL  = 6'b111111;
  localparam logic [NFLAG-1:0] WE_ZNVS = 6'b011110;
  localparam logic [NFLAG-1:0] WE_CZNVS = 6'b011111;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_CP   = 5'd4,
    OP_CPC  = 5'd5,
    OP_AND  = 5'd6,
    OP_OR   = 5'd7,
    OP_XOR  = 5'd8,
    OP_COM  = 5'd9,
    OP_NEG  = 5'd10,
    OP_INC  = 5'd11,
    OP_DEC  = 5'd12,
    OP_SWAP = 5'd13,
    OP_LSR  = 5'd14,
    OP_ROR  = 5'd15,
    OP_ASR  = 5'd16
  } alu_op_e;
endpackage

// File: rtl/mcu_alu_addsub.sv
module mcu_alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         c_out,
  output logic         h_out,
  output logic         v_out
);
  localparam int HB = W / 2;

  logic [W-1:0] yy;
  logic         cc;
  logic [W:0]   full;
  logic [HB:0]  half;

  // Subtraction as x + ~y + ~borrow; carry outputs inverted back to borrows.
  assign yy    = sub ? ~y : y;
  assign cc    = sub ? ~ci : ci;
  assign full  = {1'b0, x} + {1'b0, yy} + {{W{1'b0}}, cc};
  assign half  = {1'b0, x[HB-1:0]} + {1'b0, yy[HB-1:0]} + {{HB{1'b0}}, cc};
  assign sum   = full[W-1:0];
  assign c_out = full[W] ^ sub;
  assign h_out = half[HB] ^ sub;
  assign v_out = (x[W-1] == yy[W-1]) && (sum[W-1] != x[W-1]);
endmodule

// File: rtl/mcu_alu_logic.sv
module mcu_alu_logic
  import mcu_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [4:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] r
);
  localparam int HB = W / 2;

  always_comb begin
    case (op)
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      OP_COM:  r = ~a;
      OP_SWAP: r = {a[HB-1:0], a[W-1:HB]};
      default: r = a;
    endcase
  end
endmodule

// File: rtl/mcu_alu_shift.sv
module mcu_alu_shift
  import mcu_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [4:0]   op,
  input  logic [W-1:0] a,
  input  logic         ci,
  output logic [W-1:0] r,
  output logic         c_out
);
  logic fill;

  always_comb begin
    case (op)
      OP_ROR:  fill = ci;
      OP_ASR:  fill = a[W-1];
      default: fill = 1'b0;
    endcase
  end

  assign r     = {fill, a[W-1:1]};
  assign c_out = a[0];
endmodule

// File: rtl/mcu_alu.sv
module mcu_alu
  import mcu_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [4:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         carry_in,
  input  logic [5:0]   flags_in,
  output logic [W-1:0] result,
  output logic         result_we,
  output logic [5:0]   flags_out,
  output logic [5:0]   flags_we
);
  logic [W-1:0] ax, ay, sum, lres, sres, n_res;
  logic         aci, asub, cout, hout, vout, scout;
  logic         n_rwe, zchain, fc, fz, fn, fv, fs, fh;
  logic [NFLAG-1:0] nwe, fnew, fmerged;

  // Operand steering into the single shared adder.
  always_comb begin
    ax   = a;
    ay   = b;
    aci  = 1'b0;
    asub = 1'b0;
    case (op)
      OP_ADC:        aci = carry_in;
      OP_SUB, OP_CP: asub = 1'b1;
      OP_SBC, OP_CPC: begin
        asub = 1'b1;
        aci  = carry_in;
      end
      OP_NEG: begin
        ax   = '0;
        ay   = a;
        asub = 1'b1;
      end
      OP_INC: ay = W'(1);
      OP_DEC: begin
        ay   = W'(1);
        asub = 1'b1;
      end
      default: ;
    endcase
  end

  mcu_alu_addsub #(.W(W)) u_addsub (
    .x(ax), .y(ay), .ci(aci), .sub(asub),
    .sum(sum), .c_out(cout), .h_out(hout), .v_out(vout)
  );

  mcu_alu_logic #(.W(W)) u_logic (.op(op), .a(a), .b(b), .r(lres));

  mcu_alu_shift #(.W(W)) u_shift (
    .op(op), .a(a), .ci(carry_in), .r(sres), .c_out(scout)
  );

  always_comb begin
    n_res  = a;
    n_rwe  = 1'b1;
    nwe    = '0;
    zchain = 1'b0;
    fc     = flags_in[FC];
    fh     = flags_in[FH];
    fv     = 1'b0;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_NEG: begin
        n_res = sum; fc = cout; fh = hout; fv = vout; nwe = WE_ALL;
      end
      OP_SBC: begin
        n_res = sum; fc = cout; fh = hout; fv = vout; nwe = WE_ALL;
        zchain = 1'b1;
      end
      OP_CP: begin
        n_res = sum; fc = cout; fh = hout; fv = vout; nwe = WE_ALL;
        n_rwe = 1'b0;
      end
      OP_CPC: begin
        n_res = sum; fc = cout; fh = hout; fv = vout; nwe = WE_ALL;
        n_rwe = 1'b0; zchain = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: begin
        n_res = lres; nwe = WE_ZNVS;
      end
      OP_COM: begin
        n_res = lres; fc = 1'b1; nwe = WE_CZNVS;
      end
      OP_INC, OP_DEC: begin
        n_res = sum; fv = vout; nwe = WE_ZNVS;
      end
      OP_SWAP: n_res = lres;
      OP_LSR, OP_ROR, OP_ASR: begin
        n_res = sres; fc = scout; fv = sres[W-1] ^ scout; nwe = WE_CZNVS;
      end
      default: n_rwe = 1'b0;
    endcase
    fz = (n_res == '0) && (!zchain || flags_in[FZ]);
    fn = n_res[W-1];
    fs = fn ^ fv;
    fnew = '0;
    fnew[FC] = fc;
    fnew[FZ] = fz;
    fnew[FN] = fn;
    fnew[FV] = fv;
    fnew[FS] = fs;
    fnew[FH] = fh;
  end

  // Unwritten flags travel through unchanged.
  for (genvar i = 0; i < NFLAG; i++) begin : g_merge
    assign fmerged[i] = nwe[i] ? fnew[i] : flags_in[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      result_we <= 1'b0;
      flags_out <= '0;
      flags_we  <= '0;
    end else begin
      result    <= n_res;
      result_we <= n_rwe;
      flags_out <= fmerged;
      flags_we  <= nwe;
    end
  end
endmodule

// File: rtl/mcu_alu_chk.sv
module mcu_alu_chk
  import mcu_alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [4:0]   op,
  input logic [W-1:0] a,
  input logic [5:0]   flags_in,
  input logic [W-1:0] result,
  input logic         result_we,
  input logic [5:0]   flags_out,
  input logic [5:0]   flags_we
);
  localparam int HB = W / 2;

  logic primed = 1'b0;
  always_ff @(posedge clk) if (rst) primed <= 1'b1;

  // R1: the cycle after reset shows cleared outputs
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    primed && $past(rst) |-> (result == '0) && !result_we && (flags_we == '0) && (flags_out == '0));

  // R6
  p_sign_rule_r6: assert property (@(posedge clk) disable iff (rst)
    primed && flags_we[FS] |-> flags_out[FS] == (flags_out[FN] ^ flags_out[FV]));

  p_neg_copy_r6: assert property (@(posedge clk) disable iff (rst)
    primed && flags_we[FN] |-> flags_out[FN] == result[W-1]);

  // R4
  p_chain_z_r4: assert property (@(posedge clk) disable iff (rst)
    primed && !$past(rst) && ($past(op) == OP_SBC || $past(op) == OP_CPC) && !$past(flags_in[FZ])
      |-> !flags_out[FZ]);

  // R10
  p_incdec_carry_r10: assert property (@(posedge clk) disable iff (rst)
    primed && !$past(rst) && ($past(op) == OP_INC || $past(op) == OP_DEC)
      |-> !flags_we[FC] && (flags_out[FC] == $past(flags_in[FC])));

  // R12
  p_swap_r12: assert property (@(posedge clk) disable iff (rst)
    primed && !$past(rst) && ($past(op) == OP_SWAP)
      |-> (result == {$past(a[HB-1:0]), $past(a[W-1:HB])}) && (flags_we == '0));

  // R5
  p_cmp_nowrite_r5: assert property (@(posedge clk) disable iff (rst)
    primed && !$past(rst) && ($past(op) == OP_CP || $past(op) == OP_CPC) |-> !result_we);

  // R13
  p_passthru_r13: assert property (@(posedge clk) disable iff (rst)
    primed && !$past(rst) |-> ((flags_out ^ $past(flags_in)) & ~flags_we) == '0);
endmodule

bind mcu_alu mcu_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .op(op), .a(a), .flags_in(flags_in),
  .result(result), .result_we(result_we), .flags_out(flags_out), .flags_we(flags_we)
);

// File: tb/tb_mcu_alu.sv
module tb_mcu_alu;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 24;

  typedef struct packed {
    logic [4:0] op;
    logic [7:0] a;
    logic [7:0] b;
    logic       ci;
    logic [5:0] fin;
    logic [7:0] res;
    logic [5:0] flg;
    logic [5:0] we;
    logic       rwe;
  } vec_t;

  // flag bits: [5]H [4]S [3]V [2]N [1]Z [0]C
  localparam vec_t VECS [NV] = '{
    '{5'd0,  8'h7F, 8'h01, 1'b0, 6'b000000, 8'h80, 6'b101100, 6'b111111, 1'b1},
    '{5'd1,  8'hFF, 8'h00, 1'b1, 6'b000000, 8'h00, 6'b100011, 6'b111111, 1'b1},
    '{5'd2,  8'h10, 8'h01, 1'b0, 6'b000000, 8'h0F, 6'b100000, 6'b111111, 1'b1},
    '{5'd3,  8'h00, 8'h00, 1'b1, 6'b000010, 8'hFF, 6'b110101, 6'b111111, 1'b1},
    '{5'd5,  8'h05, 8'h05, 1'b0, 6'b000000, 8'h00, 6'b000000, 6'b111111, 1'b0},
    '{5'd5,  8'h05, 8'h05, 1'b0, 6'b000010, 8'h00, 6'b000010, 6'b111111, 1'b0},
    '{5'd4,  8'h80, 8'h01, 1'b0, 6'b000000, 8'h7F, 6'b111000, 6'b111111, 1'b0},
    '{5'd4,  8'h33, 8'h33, 1'b0, 6'b000000, 8'h00, 6'b000010, 6'b111111, 1'b0},
    '{5'd6,  8'hF0, 8'h3C, 1'b0, 6'b100001, 8'h30, 6'b100001, 6'b011110, 1'b1},
    '{5'd8,  8'hAA, 8'hAA, 1'b0, 6'b000000, 8'h00, 6'b000010, 6'b011110, 1'b1},
    '{5'd7,  8'h80, 8'h01, 1'b0, 6'b000000, 8'h81, 6'b010100, 6'b011110, 1'b1},
    '{5'd9,  8'h00, 8'h00, 1'b0, 6'b000000, 8'hFF, 6'b010101, 6'b011111, 1'b1},
    '{5'd10, 8'h80, 8'h00, 1'b0, 6'b000000, 8'h80, 6'b001101, 6'b111111, 1'b1},
    '{5'd10, 8'h00, 8'h00, 1'b0, 6'b000000, 8'h00, 6'b000010, 6'b111111, 1'b1},
    '{5'd10, 8'h01, 8'h00, 1'b0, 6'b000000, 8'hFF, 6'b110101, 6'b111111, 1'b1},
    '{5'd11, 8'h7F, 8'h00, 1'b0, 6'b000001, 8'h80, 6'b001101, 6'b011110, 1'b1},
    '{5'd12, 8'h80, 8'h00, 1'b0, 6'b000000, 8'h7F, 6'b011000, 6'b011110, 1'b1},
    '{5'd11, 8'hFF, 8'h00, 1'b0, 6'b000000, 8'h00, 6'b000010, 6'b011110, 1'b1},
    '{5'd13, 8'hA5, 8'h00, 1'b0, 6'b101010, 8'h5A, 6'b101010, 6'b000000, 1'b1},
    '{5'd14, 8'h81, 8'h00, 1'b0, 6'b100000, 8'h40, 6'b111001, 6'b011111, 1'b1},
    '{5'd15, 8'h01, 8'h00, 1'b1, 6'b000000, 8'h80, 6'b010101, 6'b011111, 1'b1},
    '{5'd16, 8'h80, 8'h00, 1'b1, 6'b000000, 8'hC0, 6'b001100, 6'b011111, 1'b1},
    '{5'd15, 8'h01, 8'h00, 1'b0, 6'b000000, 8'h00, 6'b011011, 6'b011111, 1'b1},
    '{5'd20, 8'h12, 8'h34, 1'b1, 6'b010110, 8'h12, 6'b010110, 6'b000000, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] op = '0;
  logic [7:0] a = '0;
  logic [7:0] b = '0;
  logic       carry_in = 1'b0;
  logic [5:0] flags_in = '0;
  logic [7:0] result;
  logic       result_we;
  logic [5:0] flags_out;
  logic [5:0] flags_we;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcu_alu dut (
    .clk(clk), .rst(rst), .op(op), .a(a), .b(b), .carry_in(carry_in),
    .flags_in(flags_in), .result(result), .result_we(result_we),
    .flags_out(flags_out), .flags_we(flags_we)
  );

  function automatic string tag_of(input logic [4:0] code);
    case (code)
      5'd0, 5'd1:            return "R2";
      5'd2, 5'd3:            return "R3 R4";
      5'd4, 5'd5:            return "R3 R4 R5";
      5'd6, 5'd7, 5'd8:      return "R7";
      5'd9:                  return "R8";
      5'd10:                 return "R9";
      5'd11, 5'd12:          return "R10";
      5'd13:                 return "R12";
      5'd14, 5'd15, 5'd16:   return "R11";
      default:               return "R5";
    endcase
  endfunction

  task automatic check_out(input string tag, input logic [7:0] er, input logic erwe,
                           input logic [5:0] ef, input logic [5:0] ewe);
    checks++;
    if (result !== er || result_we !== erwe || flags_out !== ef || flags_we !== ewe) begin
      fails++;
      $display("FAIL %s R6 R13: got res=%h rwe=%b flg=%b we=%b, exp res=%h rwe=%b flg=%b we=%b",
               tag, result, result_we, flags_out, flags_we, er, erwe, ef, ewe);
    end
  endtask

  task automatic drive(input logic [4:0] o, input logic [7:0] x, input logic [7:0] y,
                       input logic c, input logic [5:0] f);
    op = o; a = x; b = y; carry_in = c; flags_in = f;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [5:0] f1;
    // R1: reset state
    repeat (3) @(negedge clk);
    check_out("R1", 8'h00, 1'b0, 6'b000000, 6'b000000);
    rst = 1'b0;

    foreach (VECS[i]) begin
      drive(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].ci, VECS[i].fin);
      @(negedge clk);
      check_out(tag_of(VECS[i].op), VECS[i].res, VECS[i].rwe, VECS[i].flg, VECS[i].we);
    end

    // R4: two-byte compare, equal operands 0x0100 vs 0x0100
    drive(5'd4, 8'h00, 8'h00, 1'b0, 6'b000000);
    @(negedge clk);
    f1 = flags_out;
    drive(5'd5, 8'h01, 8'h01, f1[0], f1);
    @(negedge clk);
    check_out("R4 chain equal", 8'h00, 1'b0, 6'b000010, 6'b111111);

    // R4: 0x0100 vs 0x0001, high bytes differ only by borrow, Z must stay clear
    drive(5'd4, 8'h00, 8'h01, 1'b0, 6'b000000);
    @(negedge clk);
    f1 = flags_out;
    drive(5'd5, 8'h01, 8'h00, f1[0], f1);
    @(negedge clk);
    check_out("R4 chain unequal", 8'h00, 1'b0, 6'b000000, 6'b111111);

    // R1: reset in mid-stream clears outputs
    drive(5'd0, 8'h7F, 8'h01, 1'b0, 6'b000000);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_out("R1 mid reset", 8'h00, 1'b0, 6'b000000, 6'b000000);
    rst = 1'b0;

    // R1: one-cycle latency, output follows new input after one edge
    drive(5'd13, 8'h3C, 8'h00, 1'b0, 6'b000101);
    @(negedge clk);
    check_out("R1 R12 latency", 8'hC3, 1'b1, 6'b000101, 6'b000000);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule